// File: doc/BRIEF.md
# Key-Guarded Watchdog Reset Timer

This block is a watchdog that can pull a chip-level reset. A free-running counter advances once per clock while counting is switched on, and is compared against a programmable limit. When the counter reaches the limit, it restarts from zero. If reset generation is also switched on, the block drives a reset pulse of fixed length and latches an event flag that software can inspect after the restart.

The configuration registers are the limit, the enable pair, the event flag and the counter-clear strobe. None of them can be changed by a plain bus write. A write to one of them takes effect only when it comes right after an unlock sequence. In that sequence, the value 0xBABA goes to one key address, then 0xEB10 goes to a second key address. The unlock covers exactly one access: whatever the next bus access is, the guard closes again. The bus is a single-cycle register port, and read data is returned in the same cycle as the address.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset, the reset output is inactive (low), the counter reads 0, the limit reads 0xFFFFFFFF, and the enable and event registers read 0.
- R2: Address map: key A = 0, key B = 1, limit = 2, enable = 3, event = 4, clear = 5, counter (read only) = 6. A write to key A of 0xBABA, then a write to key B of 0xEB10, then a write to a guarded address (2 to 5) updates that register.
- R3: A write to a guarded address that does not directly follow a completed key sequence leaves the register unchanged.
- R4: A wrong value written to key A, or a wrong value written to key B, cancels the sequence, so the following guarded write has no effect.
- R5: A completed key sequence permits one guarded write only; a second guarded write right after it is ignored.
- R6: Any bus access other than the expected key step, including a read, closes the guard, so a guarded write after it is ignored.
- R7: Writing the correct key B value without a preceding key A write does not open the guard.
- R8: With enable bit 0 set, the counter rises by one every clock; with it clear, the counter holds its value.
- R9: With enable bits 0 and 1 both set, the counter reaching the limit returns the counter to 0 at the next edge, drives the reset output high for exactly 4 clocks starting that edge, and sets event bit 0.
- R10: With only enable bit 0 set, the counter still wraps to 0 after reaching the limit, but the reset output stays low and the event bit stays 0.
- R11: A guarded write of 0 to event bit 0 clears the flag; a guarded write of 1 leaves it as it was.
- R12: A guarded write of any value to the clear address returns the counter to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, same cycle |
| wdt_rst_o | output | 1 | Watchdog reset pulse, active high by default |

## Verification
The properties take for granted that the bus is a clean synchronous port. Address, data and direction are known and held for the whole cycle whenever `bus_valid` is high, and each access lasts exactly one cycle, so that "the next access" after a key step is well defined. The stimulus changes bus inputs just after a rising edge. It issues one access per cycle or an idle cycle. It never leaves an X on `bus_addr` or `bus_wdata` while `bus_valid` is asserted. The limit is kept larger than the pulse length whenever reset generation is on, so that pulses do not overlap.

// File: rtl/keyguard_wdt_pkg.sv
package keyguard_wdt_pkg;

   typedef enum logic [1:0] {
      UL_IDLE = 2'd0,
      UL_HALF = 2'd1,
      UL_OPEN = 2'd2
   } unlock_state_e;

   // register map (word addresses)
   localparam int unsigned ADR_KEY_A  = 0;
   localparam int unsigned ADR_KEY_B  = 1;
   localparam int unsigned ADR_LIMIT  = 2;
   localparam int unsigned ADR_ENABLE = 3;
   localparam int unsigned ADR_EVENT  = 4;
   localparam int unsigned ADR_CLEAR  = 5;
   localparam int unsigned ADR_COUNT  = 6;

   localparam int unsigned EN_BIT_RUN   = 0;
   localparam int unsigned EN_BIT_RESET = 1;

endpackage

// File: rtl/keyguard_unlock.sv
module keyguard_unlock
   import keyguard_wdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned KEY_W  = 16,
   parameter logic [KEY_W-1:0] KEY_A = 16'hBABA,
   parameter logic [KEY_W-1:0] KEY_B = 16'hEB10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              unlocked
);

   localparam logic [ADDR_W-1:0] A_KEY_A = ADDR_W'(ADR_KEY_A);
   localparam logic [ADDR_W-1:0] A_KEY_B = ADDR_W'(ADR_KEY_B);
   localparam logic [DATA_W-1:0] KEY_A_X = DATA_W'(KEY_A);
   localparam logic [DATA_W-1:0] KEY_B_X = DATA_W'(KEY_B);

   if (KEY_W > DATA_W) begin : g_bad_key
      $error("keyguard_unlock: KEY_W must not exceed DATA_W");
   end

   unlock_state_e state_q, state_d;
   logic          key_a_ok, key_b_ok;

   assign key_a_ok = bus_valid && bus_write && (bus_addr == A_KEY_A) && (bus_wdata == KEY_A_X);
   assign key_b_ok = bus_valid && bus_write && (bus_addr == A_KEY_B) && (bus_wdata == KEY_B_X);

   always_comb begin
      state_d = state_q;
      if (bus_valid) begin
         if (key_a_ok) begin
            state_d = UL_HALF;
         end else if ((state_q == UL_HALF) && key_b_ok) begin
            state_d = UL_OPEN;
         end else begin
            state_d = UL_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= UL_IDLE;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == UL_OPEN);

endmodule

// File: rtl/keyguard_regs.sv
module keyguard_regs
   import keyguard_wdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter logic [CNT_W-1:0] LIMIT_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              unlocked,
   input  logic              fire,
   output logic [CNT_W-1:0]  limit_q,
   output logic              en_run,
   output logic              en_reset,
   output logic              event_q,
   output logic              clear_pulse
);

   localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(ADR_LIMIT);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(ADR_ENABLE);
   localparam logic [ADDR_W-1:0] A_EVENT  = ADDR_W'(ADR_EVENT);
   localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(ADR_CLEAR);

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("keyguard_regs: CNT_W must not exceed DATA_W");
   end

   logic commit;
   logic wr_limit, wr_enable, wr_event;

   assign commit      = bus_valid && bus_write && unlocked;
   assign wr_limit    = commit && (bus_addr == A_LIMIT);
   assign wr_enable   = commit && (bus_addr == A_ENABLE);
   assign wr_event    = commit && (bus_addr == A_EVENT);
   assign clear_pulse = commit && (bus_addr == A_CLEAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q  <= LIMIT_INIT;
         en_run   <= 1'b0;
         en_reset <= 1'b0;
      end else begin
         if (wr_limit) limit_q <= bus_wdata[CNT_W-1:0];
         if (wr_enable) begin
            en_run   <= bus_wdata[EN_BIT_RUN];
            en_reset <= bus_wdata[EN_BIT_RESET];
         end
      end
   end

   // a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        event_q <= 1'b0;
      else if (fire)                     event_q <= 1'b1;
      else if (wr_event && !bus_wdata[0]) event_q <= 1'b0;
   end

endmodule

// File: rtl/keyguard_counter.sv
module keyguard_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hit
);

   if (CNT_W < 2) begin : g_bad_w
      $error("keyguard_counter: CNT_W must be at least 2");
   end

   assign hit = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (hit)    cnt_q <= '0;
      else if (run)    cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/keyguard_pulse.sv
module keyguard_pulse #(
   parameter int unsigned LEN        = 4,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trigger,
   output logic active,
   output logic pin
);

   localparam int unsigned PW = $clog2(LEN + 1);

   if (LEN < 1) begin : g_bad_len
      $error("keyguard_pulse: LEN must be at least 1");
   end

   logic [PW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (trigger)        left_q <= PW'(LEN);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign active = (left_q != '0);

   if (ACTIVE_LOW) begin : g_low
      assign pin = ~active;
   end else begin : g_high
      assign pin = active;
   end

endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
   import keyguard_wdt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned KEY_W      = 16,
   parameter logic [KEY_W-1:0] KEY_A = 16'hBABA,
   parameter logic [KEY_W-1:0] KEY_B = 16'hEB10,
   parameter int unsigned RST_CYCLES = 4,
   parameter bit          RST_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdt_rst_o
);

   localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(ADR_LIMIT);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(ADR_ENABLE);
   localparam logic [ADDR_W-1:0] A_EVENT  = ADDR_W'(ADR_EVENT);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(ADR_COUNT);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("keyguard_wdt: ADDR_W must be at least 3");
   end

   logic             unlocked;
   logic [CNT_W-1:0] limit_q, cnt_q;
   logic             en_run, en_reset, event_q, clear_pulse;
   logic             hit, fire, pulse_active;

   assign fire = hit && en_reset;

   keyguard_unlock #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
   ) u_unlock (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .unlocked(unlocked)
   );

   keyguard_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .unlocked(unlocked), .fire(fire),
      .limit_q(limit_q), .en_run(en_run), .en_reset(en_reset), .event_q(event_q),
      .clear_pulse(clear_pulse)
   );

   keyguard_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .run(en_run), .clear(clear_pulse),
      .limit(limit_q), .cnt_q(cnt_q), .hit(hit)
   );

   keyguard_pulse #(.LEN(RST_CYCLES), .ACTIVE_LOW(RST_ACTIVE_LOW)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trigger(fire), .active(pulse_active), .pin(wdt_rst_o)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_LIMIT:  bus_rdata = DATA_W'(limit_q);
         A_ENABLE: bus_rdata = DATA_W'({en_reset, en_run});
         A_EVENT:  bus_rdata = DATA_W'(event_q);
         A_COUNT:  bus_rdata = DATA_W'(cnt_q);
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/keyguard_wdt_chk.sv
module keyguard_wdt_chk
   import keyguard_wdt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned RST_CYCLES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              unlocked,
   input logic [CNT_W-1:0]  limit_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              en_run,
   input logic              hit,
   input logic              clear_pulse,
   input logic              fire,
   input logic              event_q,
   input logic              pulse_active
);

   localparam int unsigned SW = $clog2(RST_CYCLES + 1) + 1;
   localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(ADR_LIMIT);

   logic [SW-1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          since_q <= SW'(RST_CYCLES);
      else if (fire)                       since_q <= '0;
      else if (since_q < SW'(RST_CYCLES))  since_q <= since_q + 1'b1;
   end

   p_locked_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == A_LIMIT && !unlocked) |=> $stable(limit_q));

   p_single_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && unlocked) |=> !unlocked);

   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_run && !hit && !clear_pulse) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_run && !clear_pulse) |=> $stable(cnt_q));

   p_fire_effects_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (pulse_active && event_q && cnt_q == '0));

   p_event_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(event_q) |-> $past(fire));

   p_pulse_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_active == (since_q < SW'(RST_CYCLES)));

   p_clear_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clear_pulse |=> (cnt_q == '0));

endmodule

bind keyguard_wdt keyguard_wdt_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .unlocked(unlocked), .limit_q(limit_q), .cnt_q(cnt_q),
   .en_run(en_run), .hit(hit), .clear_pulse(clear_pulse), .fire(fire),
   .event_q(event_q), .pulse_active(pulse_active)
);

// File: tb/tb_keyguard_wdt.sv
module tb_keyguard_wdt;

   localparam int CLK_P  = 10;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam logic [ADDR_W-1:0] A_KA = 0, A_KB = 1, A_LIM = 2, A_EN = 3, A_EV = 4, A_CLR = 5, A_CNT = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_valid, bus_write;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata, bus_rdata;
   logic              wdt_rst_o;

   keyguard_wdt dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;
   logic mon_rd = 1'b0;
   logic [DATA_W-1:0] exp_q[$];
   string             tag_q[$];

   task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   endtask

   // driver: one access per cycle, changed just after the rising edge
   task automatic drive(input logic v, input logic w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic scored);
      @(posedge clk);
      #1;
      bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
      mon_rd = scored;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, '0, 1'b0);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      drive(1'b1, 1'b1, a, d, 1'b0);
   endtask

   task automatic unlock();
      wr(A_KA, 32'hBABA);
      wr(A_KB, 32'hEB10);
   endtask

   task automatic pwr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      unlock();
      wr(a, d);
   endtask

   task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string req);
      exp_q.push_back(e);
      tag_q.push_back(req);
      drive(1'b1, 1'b0, a, '0, 1'b1);
   endtask

   task automatic rd_val(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
      drive(1'b1, 1'b0, a, '0, 1'b0);
      @(negedge clk);
      v = bus_rdata;
   endtask

   // monitor: compares scored reads in mid-cycle
   always @(negedge clk) begin
      if (mon_rd) begin
         if (exp_q.size() == 0) begin
            check("scoreboard-empty", 32'd1, 32'd0);
         end else begin
            automatic logic [DATA_W-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, bus_rdata, e);
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      n_checks++; n_errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [DATA_W-1:0] a, b, mx;
      int first, actives;
      rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1 rst_o", {31'd0, wdt_rst_o}, 32'd0);
      rd_exp(A_CNT, 32'd0, "R1 count");
      rd_exp(A_LIM, 32'hFFFF_FFFF, "R1 limit");
      rd_exp(A_EN, 32'd0, "R1 enable");
      rd_exp(A_EV, 32'd0, "R1 event");

      // R3 guarded write with no keys
      wr(A_LIM, 32'h55);
      rd_exp(A_LIM, 32'hFFFF_FFFF, "R3 limit unchanged");

      // R2 proper unlock
      pwr(A_LIM, 32'h100);
      rd_exp(A_LIM, 32'h100, "R2 limit written");

      // R5 single use
      unlock(); wr(A_LIM, 32'h200); wr(A_LIM, 32'h300);
      rd_exp(A_LIM, 32'h200, "R5 second write ignored");

      // R4 wrong key A, then wrong key B
      wr(A_KA, 32'h1234); wr(A_KB, 32'hEB10); wr(A_LIM, 32'h400);
      rd_exp(A_LIM, 32'h200, "R4 bad key A");
      wr(A_KA, 32'hBABA); wr(A_KB, 32'hEB11); wr(A_LIM, 32'h400);
      rd_exp(A_LIM, 32'h200, "R4 bad key B");

      // R7 key B alone
      wr(A_KB, 32'hEB10); wr(A_LIM, 32'h500);
      rd_exp(A_LIM, 32'h200, "R7 key B alone");

      // R6 read between unlock and write
      unlock();
      rd_exp(A_EV, 32'd0, "R6 intervening read");
      wr(A_LIM, 32'h600);
      rd_exp(A_LIM, 32'h200, "R6 guard closed");

      // R8 hold while stopped
      rd_val(A_CNT, a); idle(5); rd_val(A_CNT, b);
      check("R8 hold", b, a);

      // R8 counting
      pwr(A_LIM, 32'h1000);
      pwr(A_EN, 32'h1);
      idle(2);
      rd_val(A_CNT, a); idle(7); rd_val(A_CNT, b);
      check("R8 step", b, a + 32'd8);

      // R12 clear, then counting resumes
      pwr(A_CLR, 32'h0);
      rd_exp(A_CNT, 32'd0, "R12 cleared");
      rd_exp(A_CNT, 32'd1, "R8 after clear");

      // R3 clear write without keys
      rd_val(A_CNT, a); wr(A_CLR, 32'h0); rd_val(A_CNT, b);
      check("R3 clear ignored", b, a + 32'd2);
      pwr(A_EN, 32'h0);

      // R10 wrap with reset generation off
      pwr(A_LIM, 32'hF);
      pwr(A_CLR, 32'h0);
      pwr(A_EN, 32'h1);
      mx = '0; actives = 0;
      for (int k = 0; k < 40; k++) begin
         rd_val(A_CNT, a);
         if (a > mx) mx = a;
         if (wdt_rst_o) actives++;
      end
      check("R10 wrap at limit", mx, 32'hF);
      check("R10 no reset", 32'(actives), 32'd0);
      rd_exp(A_EV, 32'd0, "R10 no event");
      pwr(A_EN, 32'h0);

      // R9 fire: enable written in cycle n, count hits 15 in cycle n+16
      pwr(A_CLR, 32'h0);
      pwr(A_EN, 32'h3);
      first = 0; actives = 0;
      for (int k = 1; k <= 30; k++) begin
         idle(1);
         @(negedge clk);
         if (wdt_rst_o) begin
            actives++;
            if (first == 0) first = k;
         end
      end
      check("R9 reset start", 32'(first), 32'd17);
      check("R9 reset length", 32'(actives), 32'd4);
      rd_exp(A_EV, 32'd1, "R9 event set");
      pwr(A_EN, 32'h0);
      idle(6);
      @(negedge clk);
      check("R9 reset released", {31'd0, wdt_rst_o}, 32'd0);

      // R3 event clear without keys
      wr(A_EV, 32'h0);
      rd_exp(A_EV, 32'd1, "R3 event kept");

      // R11 event clear semantics
      pwr(A_EV, 32'h1);
      rd_exp(A_EV, 32'd1, "R11 write 1 keeps");
      pwr(A_EV, 32'h0);
      rd_exp(A_EV, 32'd0, "R11 write 0 clears");
      rd_exp(A_EN, 32'd0, "R2 enable readback");

      idle(2);
      finish_run();
   end

endmodule